// File: doc/BRIEF.md
# MAC Event Interrupt and Statistics Unit

This unit sits beside a network MAC and turns single-cycle event pulses into state that software can read. Five pulse inputs set sticky bits in an 8-bit interrupt register. Three more pulse inputs each advance an 8-bit statistics counter: one for frames dropped for lack of buffer space, one for runt frames and one for collisions seen while receiving. When a counter rolls over, it raises its own overflow bit in the interrupt register.

A simple strobe port gives access to the unit. While `rdEn` is high, `rdData` shows the register chosen by `addr`, and the chosen register clears at the next clock edge. A write strobe loads the mask register, where a set bit blocks the matching interrupt bit. The single `irq` output goes high whenever any interrupt bit is set and its mask bit is clear. If an event arrives in the same cycle as the read that clears its register, the event is kept, so reading never loses a pulse.

Top module: `evt_stat_unit`

## Requirements
- R1: After reset, the interrupt register, the mask register and all three counters read as zero, and `irq` is low.
- R2: Event pulses set sticky interrupt bits at these positions: jabber bit 7, babble bit 6, collision error bit 5, receive bit 1, transmit bit 0. A bit stays set until the interrupt register is read.
- R3: `addr` 0 selects the interrupt register. A read with `rdEn` returns its value and clears every bit at that clock edge.
- R4: `addr` 4 selects the mask register. A write with `wrEn` loads `wrData`, and a read returns the mask without clearing it. `irq` equals the OR over all bits of (interrupt bit AND NOT mask bit).
- R5: Each pulse on `evtMissed`, `evtRunt` or `evtRxColl` adds one to its counter. These counters sit at `addr` 1, 2 and 3.
- R6: Reading a counter with `rdEn` returns its value and clears only that counter. The other registers are left unchanged.
- R7: A pulse on a counter that holds 255 wraps it to 0 and sets its overflow bit in the interrupt register: missed bit 2, runt bit 3, collision bit 4.
- R8: An event that arrives in the same cycle as the clearing read of its register survives that read. An interrupt bit stays set, and a counter holds 1.
- R9: A counter pulse that arrives in the same cycle as a read of that counter, while it holds 255, leaves the counter at 1 and does not set the overflow bit.
- R10: Addresses 5 to 7 read as zero and have no side effects. A write strobe at any address other than 4 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evtJabber | input | 1 | Jabber event pulse |
| evtBabble | input | 1 | Babble event pulse |
| evtCollErr | input | 1 | Collision error event pulse |
| evtRx | input | 1 | Receive done event pulse |
| evtTx | input | 1 | Transmit done event pulse |
| evtMissed | input | 1 | Missed frame count pulse |
| evtRunt | input | 1 | Runt frame count pulse |
| evtRxColl | input | 1 | Receive collision count pulse |
| rdEn | input | 1 | Read strobe; the selected register clears at the edge |
| wrEn | input | 1 | Write strobe |
| addr | input | 3 | Register select |
| wrData | input | 8 | Write data for the mask register |
| rdData | output | 8 | Selected register value, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The hard case is a clearing read and a set or increment of the same register landing on the same clock edge. The corner where a counter at 255 is both read and pulsed is the sharpest form of it. Directed sequences first pump a counter to 255, then read it while pulsing it. They also read the interrupt register while a jabber pulse arrives, and then confirm through later reads that the new value survived the clear and that no overflow bit appeared. A random phase with a fixed seed mixes reads, writes and pulses at every address and compares each read and `irq` with a bench model.

// File: rtl/evt_stat_pkg.sv
package evt_stat_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 3;
  localparam int NUM_CNT  = 3;
  localparam int CNT_BASE = 1;   // first counter address
  localparam int OVF_BASE = 2;   // overflow bit of counter 0
  localparam int A_INT    = 0;
  localparam int A_MASK   = CNT_BASE + NUM_CNT;
  localparam int B_TX     = 0;
  localparam int B_RX     = 1;
  localparam int B_CERR   = 5;
  localparam int B_BABBLE = 6;
  localparam int B_JABBER = 7;
  localparam logic [DATA_W-1:0] CNT_MAX = '1;

  typedef struct packed {
    logic               clrInt;
    logic [NUM_CNT-1:0] clrCnt;
    logic               wrMask;
  } ctlStrobe_t;

  typedef struct packed {
    logic               selInt;
    logic [NUM_CNT-1:0] selCnt;
    logic               selMask;
  } rdPick_t;
endpackage

// File: rtl/evt_stat_ctrl.sv
module evt_stat_ctrl
  import evt_stat_pkg::*;
(
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output ctlStrobe_t        ctl,
  output rdPick_t           pick
);
  always_comb begin
    pick         = '0;
    pick.selInt  = (addr == ADDR_W'(A_INT));
    pick.selMask = (addr == ADDR_W'(A_MASK));
    for (int i = 0; i < NUM_CNT; i++) begin
      pick.selCnt[i] = (addr == ADDR_W'(CNT_BASE + i));
    end
    ctl        = '0;
    ctl.clrInt = rdEn & pick.selInt;
    ctl.clrCnt = {NUM_CNT{rdEn}} & pick.selCnt;
    ctl.wrMask = wrEn & pick.selMask;
  end
endmodule

// File: rtl/evt_stat_dp.sv
module evt_stat_dp
  import evt_stat_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  ctlStrobe_t                      ctl,
  input  logic                            evtJabber,
  input  logic                            evtBabble,
  input  logic                            evtCollErr,
  input  logic                            evtRx,
  input  logic                            evtTx,
  input  logic [NUM_CNT-1:0]              cntPulse,
  input  logic [DATA_W-1:0]               wrData,
  output logic [DATA_W-1:0]               intQ,
  output logic [DATA_W-1:0]               maskQ,
  output logic [NUM_CNT-1:0][DATA_W-1:0]  cntQ
);
  logic [NUM_CNT-1:0] ovf;
  logic [DATA_W-1:0]  setBits;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic [DATA_W-1:0] cntReg;
    assign ovf[i] = cntPulse[i] & ~ctl.clrCnt[i] & (cntReg == CNT_MAX);
    always_ff @(posedge clk) begin
      if (!rst_n)              cntReg <= '0;
      else if (ctl.clrCnt[i])  cntReg <= {{(DATA_W-1){1'b0}}, cntPulse[i]};
      else if (cntPulse[i])    cntReg <= cntReg + 1'b1;
    end
    assign cntQ[i] = cntReg;
  end

  always_comb begin
    setBits           = '0;
    setBits[B_JABBER] = evtJabber;
    setBits[B_BABBLE] = evtBabble;
    setBits[B_CERR]   = evtCollErr;
    setBits[B_RX]     = evtRx;
    setBits[B_TX]     = evtTx;
    for (int i = 0; i < NUM_CNT; i++) begin
      setBits[OVF_BASE + i] = ovf[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      intQ  <= '0;
      maskQ <= '0;
    end else begin
      intQ <= (ctl.clrInt ? '0 : intQ) | setBits;
      if (ctl.wrMask) maskQ <= wrData;
    end
  end
endmodule

// File: rtl/evt_stat_rdmux.sv
module evt_stat_rdmux
  import evt_stat_pkg::*;
(
  input  rdPick_t                         pick,
  input  logic [DATA_W-1:0]               intQ,
  input  logic [DATA_W-1:0]               maskQ,
  input  logic [NUM_CNT-1:0][DATA_W-1:0]  cntQ,
  output logic [DATA_W-1:0]               rdData,
  output logic                            irq
);
  always_comb begin
    rdData = '0;
    if (pick.selInt)  rdData = intQ;
    if (pick.selMask) rdData = maskQ;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (pick.selCnt[i]) rdData = cntQ[i];
    end
  end

  assign irq = |(intQ & ~maskQ);
endmodule

// File: rtl/evt_stat_unit.sv
module evt_stat_unit
  import evt_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evtJabber,
  input  logic              evtBabble,
  input  logic              evtCollErr,
  input  logic              evtRx,
  input  logic              evtTx,
  input  logic              evtMissed,
  input  logic              evtRunt,
  input  logic              evtRxColl,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  ctlStrobe_t                     ctl;
  rdPick_t                        pick;
  logic [DATA_W-1:0]              intQ;
  logic [DATA_W-1:0]              maskQ;
  logic [NUM_CNT-1:0][DATA_W-1:0] cntQ;
  logic [NUM_CNT-1:0]             cntPulse;

  assign cntPulse = {evtRxColl, evtRunt, evtMissed};

  evt_stat_ctrl u_ctrl (
    .rdEn (rdEn),
    .wrEn (wrEn),
    .addr (addr),
    .ctl  (ctl),
    .pick (pick)
  );

  evt_stat_dp u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (ctl),
    .evtJabber  (evtJabber),
    .evtBabble  (evtBabble),
    .evtCollErr (evtCollErr),
    .evtRx      (evtRx),
    .evtTx      (evtTx),
    .cntPulse   (cntPulse),
    .wrData     (wrData),
    .intQ       (intQ),
    .maskQ      (maskQ),
    .cntQ       (cntQ)
  );

  evt_stat_rdmux u_rdmux (
    .pick   (pick),
    .intQ   (intQ),
    .maskQ  (maskQ),
    .cntQ   (cntQ),
    .rdData (rdData),
    .irq    (irq)
  );
endmodule

// File: rtl/evt_stat_chk.sv
module evt_stat_chk
  import evt_stat_pkg::*;
(
  input logic                           clk,
  input logic                           rst_n,
  input logic                           evtJabber,
  input logic                           evtBabble,
  input logic                           evtCollErr,
  input logic                           evtRx,
  input logic                           evtTx,
  input logic [NUM_CNT-1:0]             cntPulse,
  input logic                           rdEn,
  input logic [ADDR_W-1:0]              addr,
  input logic [DATA_W-1:0]              intQ,
  input logic [DATA_W-1:0]              maskQ,
  input logic [NUM_CNT-1:0][DATA_W-1:0] cntQ,
  input logic                           irq
);
  logic anyEvt;
  logic intRead;
  assign anyEvt  = evtJabber | evtBabble | evtCollErr | evtRx | evtTx | (|cntPulse);
  assign intRead = rdEn && (addr == ADDR_W'(A_INT));

  // R3: a clean read of the interrupt register empties it and drops irq
  p_int_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    intRead && !anyEvt |=> (intQ == '0) && !irq);

  // R2: a set jabber bit stays set until read
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    intQ[B_JABBER] && !intRead |=> intQ[B_JABBER]);

  // R8: a jabber pulse during the clearing read survives
  p_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    intRead && evtJabber |=> intQ[B_JABBER]);

  // R4: a fully set mask silences the request
  p_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (maskQ == '1) |-> !irq);

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt_chk
    logic cntRead;
    assign cntRead = rdEn && (addr == ADDR_W'(CNT_BASE + i));

    // R6: a read without a pulse clears the counter
    p_cnt_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cntRead && !cntPulse[i] |=> cntQ[i] == '0);

    // R5: a pulse below the maximum adds one
    p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !cntRead && cntPulse[i] && (cntQ[i] != CNT_MAX) |=> cntQ[i] == $past(cntQ[i]) + 1'b1);

    // R7: a pulse at the maximum wraps and flags overflow
    p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cntRead && cntPulse[i] && (cntQ[i] == CNT_MAX) |=> (cntQ[i] == '0) && intQ[OVF_BASE + i]);

    // R9: read and pulse together leave the counter at one
    p_read_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cntRead && cntPulse[i] |=> cntQ[i] == DATA_W'(1));
  end
endmodule

bind evt_stat_unit evt_stat_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .evtJabber  (evtJabber),
  .evtBabble  (evtBabble),
  .evtCollErr (evtCollErr),
  .evtRx      (evtRx),
  .evtTx      (evtTx),
  .cntPulse   (cntPulse),
  .rdEn       (rdEn),
  .addr       (addr),
  .intQ       (intQ),
  .maskQ      (maskQ),
  .cntQ       (cntQ),
  .irq        (irq)
);

// File: tb/evt_stat_unit_bench.sv
`timescale 1ns/1ps
module evt_stat_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evtJabber = 0, evtBabble = 0, evtCollErr = 0, evtRx = 0, evtTx = 0;
  logic       evtMissed = 0, evtRunt = 0, evtRxColl = 0;
  logic       rdEn = 0, wrEn = 0;
  logic [2:0] addr = 0;
  logic [7:0] wrData = 0;
  logic [7:0] rdData;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] mInt = 0, mMask = 0;
  logic [7:0] mCnt [3];

  always #2.5 clk = ~clk;

  evt_stat_unit u_evt_stat_unit (
    .clk(clk), .rst_n(rst_n),
    .evtJabber(evtJabber), .evtBabble(evtBabble), .evtCollErr(evtCollErr),
    .evtRx(evtRx), .evtTx(evtTx),
    .evtMissed(evtMissed), .evtRunt(evtRunt), .evtRxColl(evtRxColl),
    .rdEn(rdEn), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irq(irq)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] modelRead(input logic [2:0] a);
    case (a)
      3'd0: return mInt;
      3'd1: return mCnt[0];
      3'd2: return mCnt[1];
      3'd3: return mCnt[2];
      3'd4: return mMask;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tagFor(input logic [2:0] a);
    if (a == 3'd0) return "R3";
    if (a == 3'd4) return "R4";
    if (a > 3'd4) return "R10";
    return "R6";
  endfunction

  task automatic modelStep();
    logic [7:0] setB;
    logic [2:0] pul;
    pul  = {evtRxColl, evtRunt, evtMissed};
    setB = {evtJabber, evtBabble, evtCollErr, 3'b000, evtRx, evtTx};
    for (int i = 0; i < 3; i++) begin
      if (rdEn && addr == 3'(i + 1)) mCnt[i] = {7'd0, pul[i]};
      else if (pul[i]) begin
        if (mCnt[i] == 8'hFF) setB[2 + i] = 1'b1;
        mCnt[i] = mCnt[i] + 8'd1;
      end
    end
    mInt = ((rdEn && addr == 3'd0) ? 8'h00 : mInt) | setB;
    if (wrEn && addr == 3'd4) mMask = wrData;
  endtask

  task automatic idle();
    {evtJabber, evtBabble, evtCollErr, evtRx, evtTx} = '0;
    {evtMissed, evtRunt, evtRxColl} = '0;
    rdEn = 0; wrEn = 0;
  endtask

  // call just after a falling edge with inputs applied
  task automatic tick(input string tag);
    #1;
    chk(rdData, modelRead(addr), tag);
    chk({7'd0, irq}, {7'd0, |(mInt & ~mMask)}, "R4");
    modelStep();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic peek(input logic [2:0] a, input logic [7:0] exp, input string tag);
    addr = a; rdEn = 0;
    #1 chk(rdData, exp, tag);
    tick(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) mCnt[i] = 8'h00;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 5; a++) peek(3'(a), 8'h00, "R1");
    chk({7'd0, irq}, 8'h00, "R1");

    // R2 event bits
    evtJabber = 1; evtTx = 1; evtBabble = 1; evtCollErr = 1; evtRx = 1; addr = 3'd5; tick("R2");
    peek(3'd0, 8'hE3, "R2");
    // R3 read clears
    addr = 3'd0; rdEn = 1; #1 chk(rdData, 8'hE3, "R3"); tick("R3");
    peek(3'd0, 8'h00, "R3");

    // R4 mask
    addr = 3'd4; wrEn = 1; wrData = 8'h01; tick("R4");
    evtTx = 1; addr = 3'd5; tick("R4");
    #1 chk({7'd0, irq}, 8'h00, "R4 masked tx");
    evtRx = 1; tick("R4");
    #1 chk({7'd0, irq}, 8'h01, "R4 unmasked rx");
    peek(3'd4, 8'h01, "R4");
    addr = 3'd0; rdEn = 1; tick("R3");

    // R5 / R6 counting and clearing
    for (int k = 0; k < 5; k++) begin evtMissed = 1; addr = 3'd5; tick("R5"); end
    evtRunt = 1; addr = 3'd5; tick("R5");
    addr = 3'd1; rdEn = 1; #1 chk(rdData, 8'd5, "R6"); tick("R6");
    peek(3'd1, 8'd0, "R6");
    peek(3'd2, 8'd1, "R6 other counter kept");
    addr = 3'd2; rdEn = 1; tick("R6");

    // R7 wrap of runt counter
    for (int k = 0; k < 256; k++) begin evtRunt = 1; addr = 3'd5; tick("R7"); end
    peek(3'd2, 8'd0, "R7 wrapped");
    peek(3'd0, 8'h08, "R7 overflow bit");

    // R8 jabber during interrupt read
    addr = 3'd0; rdEn = 1; evtJabber = 1; tick("R8");
    peek(3'd0, 8'h80, "R8");
    addr = 3'd0; rdEn = 1; tick("R3");

    // R9 collision counter at max, read and pulse together
    for (int k = 0; k < 255; k++) begin evtRxColl = 1; addr = 3'd5; tick("R5"); end
    addr = 3'd3; rdEn = 1; evtRxColl = 1; #1 chk(rdData, 8'hFF, "R9"); tick("R9");
    peek(3'd3, 8'd1, "R9 count");
    peek(3'd0, 8'h00, "R9 no overflow");
    addr = 3'd3; rdEn = 1; tick("R6");

    // R10 unused addresses and stray writes
    evtTx = 1; tick("R10");
    addr = 3'd6; rdEn = 1; #1 chk(rdData, 8'h00, "R10"); tick("R10");
    addr = 3'd0; wrEn = 1; wrData = 8'hFF; tick("R10");
    peek(3'd4, 8'h01, "R10 mask kept");
    peek(3'd0, 8'h01, "R10 int kept");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] a;
      a = 3'($urandom % 8);
      evtJabber  = ($urandom % 16) == 0;
      evtBabble  = ($urandom % 16) == 0;
      evtCollErr = ($urandom % 16) == 0;
      evtRx      = ($urandom % 8) == 0;
      evtTx      = ($urandom % 8) == 0;
      evtMissed  = ($urandom % 2) == 0;
      evtRunt    = ($urandom % 2) == 0;
      evtRxColl  = ($urandom % 2) == 0;
      rdEn       = ($urandom % 12) == 0;
      wrEn       = ($urandom % 10) == 0;
      wrData     = 8'($urandom);
      addr       = a;
      tick(tagFor(a));
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule